// File: doc/BRIEF.md
# Edge-Triggered Pending Interrupt Controller

This block turns a set of asynchronous, active-low interrupt lines into a 16-bit pending word and tells the processor core which request to take. Six user lines and two I/O-level lines are latched on their falling edges. The power-fail line is different: while it is held low, pending bit 15 is set. Each pending bit is ANDed with an effective mask. That mask is the software-written enable register with bit 15 forced to one, so power-fail can never be masked. The highest-numbered surviving bit drives the request output and its index.

Software writes and reads the enable mask through a simple write strobe. It reads the pending word directly and retires requests by writing ones to a clear port. A pending bit is never dropped because it is masked. It stays set until it is cleared or the block is reset, so a request that arrives while masked is taken as soon as software enables it. Vectoring, context save and instruction sequencing belong to the core and are not part of this block.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, `pend_o`, `mask_rdata_o`, `irq_o` and `irq_id_o` are all zero until an input event or a register write occurs.
- R2: A falling edge on user line `usr_irq_ni[n]` sets pending bit 7+n. Holding the line low or raising it sets nothing further.
- R3: A falling edge on I/O-level line `io_irq_ni[n]` sets pending bit 13+n.
- R4: While `pwr_fail_ni` is low, pending bit 15 is set on every cycle, and a clear of bit 15 has no lasting effect. After the line returns high, the bit can be cleared.
- R5: A cycle with `mask_we_i` high stores `mask_wdata_i` bits 15..7 in the mask. `mask_rdata_o` returns them with bits 6..0 reading zero, and the mask holds its value when `mask_we_i` is low. A mask bit of 1 enables the matching request.
- R6: `irq_o` is high exactly when pending AND (mask with bit 15 forced to 1) is nonzero. Pending bit 15 therefore always requests.
- R7: `irq_id_o` is the index of the highest set bit of pending AND the effective mask, and is 0 when `irq_o` is low.
- R8: A masked pending bit stays set. Enabling its mask bit later raises `irq_o` with that index.
- R9: A cycle with `clr_we_i` high clears every pending bit whose `clr_bits_i` bit is 1. If a new set event for a bit arrives in the same cycle, the bit stays set.
- R10: An input edge becomes visible on `pend_o` at the third rising clock edge after the line changes, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| usr_irq_ni | input | 6 | User interrupt lines, falling-edge active |
| io_irq_ni | input | 2 | I/O-level interrupt lines, falling-edge active |
| pwr_fail_ni | input | 1 | Power-fail line, active low, level sensitive |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 16 | Mask write data |
| mask_rdata_o | output | 16 | Current mask value |
| clr_we_i | input | 1 | Pending clear strobe |
| clr_bits_i | input | 16 | Write-one-to-clear pattern |
| pend_o | output | 16 | Pending interrupt word |
| irq_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 4 | Index of the winning request |

## Verification
The bench goes after several corner cases:

- A line held low after its edge. A level-sensitive design would set the bit again after software clears it.
- A clear that lands in the same cycle as a fresh edge. A design that gives the clear priority would lose that interrupt.
- A power-fail bit with every mask bit at zero, and a clear of bit 15 while the line is still low. A design that masks bit 15, or lets the clear stick, stays silent.
- The exact latency through the synchronizer, and the choice of winner among several enabled requests. A wrong pipeline depth or a reversed priority encoder fails these checks.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned ID_W     = $clog2(REG_W);
  localparam int unsigned USR_N    = 6;
  localparam int unsigned IO_N     = 2;
  localparam int unsigned USR_LSB  = 7;
  localparam int unsigned IO_LSB   = USR_LSB + USR_N;
  localparam int unsigned PF_BIT   = IO_LSB + IO_N;
  localparam int unsigned IN_W     = USR_N + IO_N + 1;

  typedef logic [REG_W-1:0] word_t;
  typedef logic [ID_W-1:0]  id_t;

  function automatic word_t impl_bits();
    word_t m;
    m = '0;
    for (int i = USR_LSB; i <= PF_BIT; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam word_t IMPL_MASK = impl_bits();
  localparam word_t PF_ONEHOT = word_t'(1) << PF_BIT;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {W{RST_VAL}};
      else         stg_q[s] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_fall_det.sv
module irq_fall_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  // high last cycle, low now
  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W   = 16,
  parameter int unsigned IDW = $clog2(W)
) (
  input  logic [W-1:0]   req_i,
  output logic           any_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    any_o = 1'b0;
    id_o  = '0;
    // ascending scan: the last hit is the highest index
    for (int i = 0; i < W; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        id_o  = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [USR_N-1:0]    usr_irq_ni,
  input  logic [IO_N-1:0]     io_irq_ni,
  input  logic                pwr_fail_ni,
  input  logic                mask_we_i,
  input  logic [REG_W-1:0]    mask_wdata_i,
  output logic [REG_W-1:0]    mask_rdata_o,
  input  logic                clr_we_i,
  input  logic [REG_W-1:0]    clr_bits_i,
  output logic [REG_W-1:0]    pend_o,
  output logic                irq_o,
  output logic [ID_W-1:0]     irq_id_o
);
  logic [IN_W-1:0] raw_n, sync_n, fall;
  word_t           set_vec, clr_vec, pend_q, pend_d, mask_q, eff_mask;

  assign raw_n = {pwr_fail_ni, io_irq_ni, usr_irq_ni};

  irq_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_n),
    .q_o    (sync_n)
  );

  irq_fall_det #(.W(IN_W)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_n),
    .fall_o (fall)
  );

  always_comb begin
    set_vec = '0;
    set_vec[USR_LSB +: USR_N] = fall[USR_N-1:0];
    set_vec[IO_LSB +: IO_N]   = fall[USR_N +: IO_N];
    set_vec[PF_BIT]           = ~sync_n[IN_W-1];  // level: held while asserted
  end

  assign clr_vec = clr_we_i ? (clr_bits_i & IMPL_MASK) : '0;
  assign pend_d  = ((pend_q & ~clr_vec) | set_vec) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_wdata_i & IMPL_MASK;
  end

  assign eff_mask = mask_q | PF_ONEHOT;

  irq_prio_enc #(.W(REG_W), .IDW(ID_W)) u_prio (
    .req_i (pend_q & eff_mask),
    .any_o (irq_o),
    .id_o  (irq_id_o)
  );

  assign pend_o       = pend_q;
  assign mask_rdata_o = mask_q;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk
  import irq_pend_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mask_we_i,
  input logic [REG_W-1:0] mask_wdata_i,
  input logic [REG_W-1:0] mask_rdata_o,
  input logic             clr_we_i,
  input logic [REG_W-1:0] clr_bits_i,
  input logic [REG_W-1:0] pend_o,
  input logic             irq_o,
  input logic [ID_W-1:0]  irq_id_o
);
  word_t eff, act;
  assign eff = mask_rdata_o | PF_ONEHOT;
  assign act = pend_o & eff;

  assert_mask_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_rdata_o == ($past(mask_wdata_i) & IMPL_MASK));

  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_rdata_o));

  assert_irq_iff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (act != '0));

  assert_pf_unmaskable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[PF_BIT] |-> (irq_o && irq_id_o == ID_W'(PF_BIT)));

  assert_top_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((act >> irq_id_o) == word_t'(1)));

  assert_idle_id_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> irq_id_o == '0);

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend_o) & ~($past(clr_we_i) ? $past(clr_bits_i) : '0)
              & ~pend_o) == '0));
endmodule

bind irq_pend_ctrl irq_pend_chk u_chk (.*);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  usr_irq_ni = '1;
  logic [1:0]  io_irq_ni = '1;
  logic        pwr_fail_ni = 1'b1;
  logic        mask_we_i = 1'b0;
  logic [15:0] mask_wdata_i = '0;
  logic [15:0] mask_rdata_o;
  logic        clr_we_i = 1'b0;
  logic [15:0] clr_bits_i = '0;
  logic [15:0] pend_o;
  logic        irq_o;
  logic [3:0]  irq_id_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_pend_ctrl u_irq_pend_ctrl (.*);

  typedef struct packed {
    logic        pf;
    logic [1:0]  io;
    logic [5:0]  usr;
    logic [15:0] mask;
    logic        irq;
    logic [3:0]  id;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 2'b00, 6'b000001, 16'h0080, 1'b1, 4'd7},
    '{1'b0, 2'b00, 6'b100001, 16'h0080, 1'b1, 4'd7},
    '{1'b0, 2'b00, 6'b100001, 16'h1080, 1'b1, 4'd12},
    '{1'b0, 2'b01, 6'b111111, 16'h0000, 1'b0, 4'd0},
    '{1'b0, 2'b11, 6'b000000, 16'h4000, 1'b1, 4'd14},
    '{1'b1, 2'b11, 6'b111111, 16'h0000, 1'b1, 4'd15},
    '{1'b0, 2'b10, 6'b010000, 16'hFF80, 1'b1, 4'd14}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; usr_irq_ni = '1; io_irq_ni = '1; pwr_fail_ni = 1'b1;
    tick(2);
    rst_ni = 1'b1;
    tick(1);
  endtask

  task automatic wr_mask(input logic [15:0] v);
    mask_we_i = 1'b1; mask_wdata_i = v;
    tick(1);
    mask_we_i = 1'b0;
  endtask

  task automatic clr(input logic [15:0] v);
    clr_we_i = 1'b1; clr_bits_i = v;
    tick(1);
    clr_we_i = 1'b0; clr_bits_i = '0;
  endtask

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 mask", 32'(mask_rdata_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 idle after release", 32'({irq_o, irq_id_o, pend_o}), 0);

    // table walk: R2 R3 R6 R7
    foreach (VECS[k]) begin
      do_reset();
      wr_mask(VECS[k].mask);
      usr_irq_ni = ~VECS[k].usr; io_irq_ni = ~VECS[k].io; pwr_fail_ni = ~VECS[k].pf;
      tick(4);
      chk($sformatf("R2_R3 vec%0d pend", k), 32'(pend_o),
          32'({VECS[k].pf, VECS[k].io, VECS[k].usr, 7'b0}));
      chk($sformatf("R6 vec%0d irq", k), 32'(irq_o), 32'(VECS[k].irq));
      chk($sformatf("R7 vec%0d id", k), 32'(irq_id_o), 32'(VECS[k].id));
      usr_irq_ni = '1; io_irq_ni = '1; pwr_fail_ni = 1'b1;
      tick(4);
    end

    // R5 mask storage and readback
    do_reset();
    wr_mask(16'hFFFF);
    chk("R5 readback", 32'(mask_rdata_o), 32'h0000FF80);
    tick(3);
    chk("R5 hold", 32'(mask_rdata_o), 32'h0000FF80);

    // R10 latency
    do_reset();
    usr_irq_ni[2] = 1'b0;
    tick(2);
    chk("R10 not yet after two edges", 32'(pend_o), 0);
    tick(1);
    chk("R10 set at third edge", 32'(pend_o), 32'h00000200);

    // R2 steady low / rising does not re-set
    clr(16'h0200);
    chk("R9 plain clear", 32'(pend_o), 0);
    tick(4);
    chk("R2 held low no reset", 32'(pend_o), 0);
    usr_irq_ni[2] = 1'b1;
    tick(4);
    chk("R2 rising no set", 32'(pend_o), 0);

    // R8 masked stays, unmask raises
    do_reset();
    io_irq_ni[0] = 1'b0;
    tick(4);
    io_irq_ni[0] = 1'b1;
    tick(8);
    chk("R8 masked still pending", 32'(pend_o), 32'h00002000);
    chk("R8 masked no irq", 32'(irq_o), 0);
    wr_mask(16'h2000);
    chk("R8 unmask irq", 32'({irq_o, irq_id_o}), 32'h1D);

    // R9 clear vs simultaneous new edge
    do_reset();
    usr_irq_ni[0] = 1'b0; tick(4); usr_irq_ni[0] = 1'b1; tick(4);
    chk("R9 preset", 32'(pend_o), 32'h00000080);
    usr_irq_ni[0] = 1'b0;       // edge reaches pending at third edge
    tick(2);
    clr_we_i = 1'b1; clr_bits_i = 16'h0080;
    tick(1);
    clr_we_i = 1'b0; clr_bits_i = '0;
    chk("R9 set wins over clear", 32'(pend_o), 32'h00000080);
    usr_irq_ni[0] = 1'b1;

    // R4 power fail level behaviour
    do_reset();
    pwr_fail_ni = 1'b0;
    tick(4);
    chk("R4 pf pending", 32'({irq_o, irq_id_o, pend_o}), 32'h1F8000);
    clr(16'h8000);
    tick(1);
    chk("R4 clear ineffective while held", 32'(pend_o), 32'h00008000);
    pwr_fail_ni = 1'b1;
    tick(4);
    clr(16'h8000);
    chk("R4 clear after release", 32'(pend_o), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule